// File: doc/BRIEF.md
# Three-Phase Complementary PWM with Dead-Time Insertion

This block drives three inverter legs. Each leg has a high-side gate and a low-side gate. A main triangle counter runs from 0 up to `period` and back down. A lag counter follows it exactly `dead` cycles behind. The main counter sets when a gate turns off and the lag counter sets when a gate turns on, so a gate always waits `dead` cycles after its partner has released before it switches on.

Each leg keeps two buffered copies of its duty value, one per counter. Each copy reloads only when its own counter reaches the top or the bottom of the triangle. This keeps every half-period consistent when firmware changes the duty in mid-cycle. Turn-off events always win. When a leg's off-window is too short to fit the delayed turn-on, the turn-on is discarded and that gate stays low for the whole cycle, so no narrow sliver pulse reaches the power stage. A polarity bit for each leg inverts both of its gates after all timing decisions have been made.

Configuration (`period`, `dead`) is held static while `en` is high. The legal ranges are `period` >= 2, `dead` >= 1, and duty within 1..`period`-1.

Top module: `cpwm_top`

## Requirements
- R1: For every leg, the high-side and low-side gates are never active in the same cycle.
- R2: With duty c, half-period P and dead time D, in steady state the active width per 2P-cycle period is 2(P-c)-D for the high side and 2c-D for the low side. After either gate turns off, its partner turns on exactly D cycles later.
- R3: When 2(P-c) <= D, the high side stays inactive for the whole period. A tie counts as suppressed, because turn-off wins over turn-on.
- R4: When 2c <= D, the low side stays inactive for the whole period.
- R5: A duty input change that is removed again before either counter reaches a turning point (0 or P) has no effect on the gate waveforms.
- R6: While reset is asserted, and after release until `en` rises, every gate sits at its inactive level, which is the leg's `pol` bit.
- R7: Gate pin = active level XOR `pol[i]`. `pol[i]`=1 makes both gates of leg i active-low.
- R8: While `en` is low, all six gate pins hold their values. After `en` returns, the widths of R2 apply again.
- R9: A duty change that is held steady is applied from the next turning point onward, and the widths then follow R2 for the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Count enable; low freezes counters and gates |
| period | input | CW | Triangle peak value P |
| dead | input | CW | Dead time D in cycles |
| duty | input | NPH x CW | Duty compare value for each leg |
| pol | input | NPH | Polarity select for each leg (1 = active-low gates) |
| gate_hi | output | NPH | High-side gate for each leg |
| gate_lo | output | NPH | Low-side gate for each leg |

## Verification
The hardest case to reach from the ports is a duty change landing inside the few cycles between a main-counter turn-off and the delayed lag-counter turn-on. A buffer that reloads too early would only show up as a one-cycle wider pulse. The stimulus watches for the falling edge of the low-side gate. At that point the lag counter sits just below the compare value. The bench then drives the duty one step lower for a single cycle and measures a full period straight away, with no settling time. The suppression cases are reached by choosing duty values at and next to the 2(P-c) = D and 2c = D boundaries.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {DIR_DN = 1'b0, DIR_UP = 1'b1} dir_e;

  // Compare events seen by one leg in one cycle
  typedef struct packed {
    logic neg_off;  // main counter, rising slope
    logic pos_off;  // main counter, falling slope
    logic pos_on;   // lag counter, rising slope
    logic neg_on;   // lag counter, falling slope
  } evt_t;
endpackage

// File: rtl/cpwm_tri_cnt.sv
module cpwm_tri_cnt
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output dir_e          dir,
  output logic          turn
);
  logic [CW-1:0] cnt_q, cnt_d;
  dir_e          dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (tick) begin
      if (dir_q == DIR_UP) begin
        if (cnt_q >= period) begin
          cnt_d = cnt_q - 1'b1;
          dir_d = DIR_DN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = cnt_q + 1'b1;
          dir_d = DIR_UP;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_DN;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt  = cnt_q;
  assign dir  = dir_q;
  assign turn = (cnt_q == '0) || (cnt_q == period);
endmodule

// File: rtl/cpwm_cmp.sv
module cpwm_cmp
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          turn,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] cnt,
  input  dir_e          dir,
  output logic          up_hit,
  output logic          dn_hit
);
  logic [CW-1:0] buf_q, buf_d;
  logic          eq;

  always_comb begin
    buf_d = buf_q;
    if (tick && turn) buf_d = duty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end

  // A zero buffer (only before the first load) never matches
  assign eq     = tick && (buf_q != '0) && (cnt == buf_q);
  assign up_hit = eq && (dir == DIR_UP);
  assign dn_hit = eq && (dir == DIR_DN);
endmodule

// File: rtl/cpwm_leg.sv
module cpwm_leg
  import cpwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t ev,
  output logic pos,
  output logic neg
);
  logic pos_q, pos_d, neg_q, neg_d;
  logic arm_pos_q, arm_pos_d, arm_neg_q, arm_neg_d;

  always_comb begin
    pos_d     = pos_q;
    neg_d     = neg_q;
    arm_pos_d = arm_pos_q;
    arm_neg_d = arm_neg_q;
    // turn-off events first: they close the opposite window
    if (ev.neg_off) begin
      neg_d     = 1'b0;
      arm_pos_d = 1'b1;
      arm_neg_d = 1'b0;
    end
    if (ev.pos_off) begin
      pos_d     = 1'b0;
      arm_neg_d = 1'b1;
      arm_pos_d = 1'b0;
    end
    // turn-on only while still armed after the off handling
    if (ev.pos_on && arm_pos_d && !ev.pos_off) pos_d = 1'b1;
    if (ev.neg_on && arm_neg_d && !ev.neg_off) neg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= 1'b0;
      neg_q     <= 1'b0;
      arm_pos_q <= 1'b0;
      arm_neg_q <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      neg_q     <= neg_d;
      arm_pos_q <= arm_pos_d;
      arm_neg_q <= arm_neg_d;
    end
  end

  assign pos = pos_q;
  assign neg = neg_q;
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int NPH = 3,
  parameter int CW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [CW-1:0]           period,
  input  logic [CW-1:0]           dead,
  input  logic [NPH-1:0][CW-1:0]  duty,
  input  logic [NPH-1:0]          pol,
  output logic [NPH-1:0]          gate_hi,
  output logic [NPH-1:0]          gate_lo
);
  logic rst_meta_n, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_s_n    <= rst_meta_n;
    end
  end

  // Lag counter starts after the main counter has made `dead` steps
  logic [CW-1:0] dly_q, dly_d;
  logic          lag_run_q, lag_run_d;

  always_comb begin
    dly_d     = dly_q;
    lag_run_d = lag_run_q;
    if (en && !lag_run_q) begin
      dly_d = dly_q + 1'b1;
      if (dly_d == dead) lag_run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dly_q     <= '0;
      lag_run_q <= 1'b0;
    end else begin
      dly_q     <= dly_d;
      lag_run_q <= lag_run_d;
    end
  end

  logic          m_tick, l_tick, m_turn, l_turn;
  logic [CW-1:0] m_cnt, l_cnt;
  dir_e          m_dir, l_dir;

  assign m_tick = en;
  assign l_tick = en && lag_run_q;

  cpwm_tri_cnt #(.CW(CW)) u_main (
    .clk(clk), .rst_n(rst_s_n), .tick(m_tick), .period(period),
    .cnt(m_cnt), .dir(m_dir), .turn(m_turn)
  );

  cpwm_tri_cnt #(.CW(CW)) u_lag (
    .clk(clk), .rst_n(rst_s_n), .tick(l_tick), .period(period),
    .cnt(l_cnt), .dir(l_dir), .turn(l_turn)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_leg
    evt_t ev;
    logic pos, neg;

    cpwm_cmp #(.CW(CW)) u_cmp_m (
      .clk(clk), .rst_n(rst_s_n), .tick(m_tick), .turn(m_turn),
      .duty(duty[i]), .cnt(m_cnt), .dir(m_dir),
      .up_hit(ev.neg_off), .dn_hit(ev.pos_off)
    );

    cpwm_cmp #(.CW(CW)) u_cmp_l (
      .clk(clk), .rst_n(rst_s_n), .tick(l_tick), .turn(l_turn),
      .duty(duty[i]), .cnt(l_cnt), .dir(l_dir),
      .up_hit(ev.pos_on), .dn_hit(ev.neg_on)
    );

    cpwm_leg u_leg (
      .clk(clk), .rst_n(rst_s_n), .ev(ev), .pos(pos), .neg(neg)
    );

    assign gate_hi[i] = pos ^ pol[i];
    assign gate_lo[i] = neg ^ pol[i];
  end
endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk #(
  parameter int NPH = 3,
  parameter int CW  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic [CW-1:0]        dead,
  input logic [NPH-1:0]       pol,
  input logic [NPH-1:0]       hi,
  input logic [NPH-1:0]       lo
);
  logic [NPH-1:0] act_hi, act_lo;
  assign act_hi = hi ^ pol;
  assign act_lo = lo ^ pol;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(hi) && $stable(lo)));

  for (genvar i = 0; i < NPH; i++) begin : g_chk
    logic [CW-1:0] lo_idle_q, hi_idle_q;

    // cycles each gate has spent inactive, saturating
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_idle_q <= '1;
        hi_idle_q <= '1;
      end else begin
        lo_idle_q <= act_lo[i] ? '0 : ((lo_idle_q == '1) ? lo_idle_q : lo_idle_q + 1'b1);
        hi_idle_q <= act_hi[i] ? '0 : ((hi_idle_q == '1) ? hi_idle_q : hi_idle_q + 1'b1);
      end
    end

    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_hi[i] && act_lo[i]));

    assert_hi_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_hi[i]) |-> (lo_idle_q >= dead));

    assert_lo_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_lo[i]) |-> (hi_idle_q >= dead));
  end
endmodule

bind cpwm_top cpwm_chk #(.NPH(NPH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dead(dead), .pol(pol),
  .hi(gate_hi), .lo(gate_lo)
);

// File: tb/tb_cpwm_top.sv
`timescale 1ns/1ps
module tb_cpwm_top;
  localparam int NPH = 3;
  localparam int CW  = 16;

  logic                   clk;
  logic                   rst_n;
  logic                   en;
  logic [CW-1:0]          period;
  logic [CW-1:0]          dead;
  logic [NPH-1:0][CW-1:0] duty;
  logic [NPH-1:0]         pol;
  logic [NPH-1:0]         gate_hi, gate_lo;
  logic [NPH-1:0]         act_hi, act_lo;

  cpwm_top #(.NPH(NPH), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .dead(dead),
    .duty(duty), .pol(pol), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  assign act_hi = gate_hi ^ pol;
  assign act_lo = gate_lo ^ pol;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;

  typedef struct {
    int    ph;
    int    pw;
    int    nw;
    string req;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // driver side: expected widths from the R2/R3/R4 formulas
  task automatic push_exp(int p, int dt, string req);
    for (int ph = 0; ph < NPH; ph++) begin
      exp_t e;
      int c;
      c    = int'(duty[ph]);
      e.ph = ph;
      e.pw = 2 * (p - c) - dt;
      e.nw = 2 * c - dt;
      if (e.pw < 0) e.pw = 0;
      if (e.nw < 0) e.nw = 0;
      e.req = (e.pw == 0) ? "R3" : ((e.nw == 0) ? "R4" : req);
      sbq.push_back(e);
    end
  endtask

  // monitor side: count active cycles over one full period, pop and compare
  task automatic monitor_window(int p, int settle);
    int hc[NPH];
    int lc[NPH];
    for (int ph = 0; ph < NPH; ph++) begin
      hc[ph] = 0;
      lc[ph] = 0;
    end
    repeat (settle) @(negedge clk);
    for (int k = 0; k < 2 * p; k++) begin
      @(negedge clk);
      for (int ph = 0; ph < NPH; ph++) begin
        hc[ph] += act_hi[ph] ? 1 : 0;
        lc[ph] += act_lo[ph] ? 1 : 0;
        if (act_hi[ph] && act_lo[ph])
          chk(1'b0, "R1", $sformatf("leg%0d overlap", ph), 1, 0);
      end
    end
    while (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(hc[e.ph] == e.pw, e.req, $sformatf("leg%0d high-side width", e.ph), hc[e.ph], e.pw);
      chk(lc[e.ph] == e.nw, e.req, $sformatf("leg%0d low-side width", e.ph), lc[e.ph], e.nw);
    end
  endtask

  // low-side release to high-side turn-on distance
  task automatic check_gap(int p, int dt, int ph);
    logic prev;
    bit   found;
    found = 1'b0;
    @(negedge clk);
    prev = act_lo[ph];
    for (int k = 0; k < 4 * p && !found; k++) begin
      @(negedge clk);
      if (prev && !act_lo[ph]) begin
        int g;
        g = 0;
        while (!act_hi[ph] && g < 4 * p) begin
          @(negedge clk);
          g++;
        end
        chk(g == dt, "R2", $sformatf("leg%0d dead gap", ph), g, dt);
        found = 1'b1;
      end
      prev = act_lo[ph];
    end
    if (!found) chk(1'b0, "R2", "no low-side release seen", 0, 1);
  endtask

  task automatic apply_cfg(int p, int dt, int d0, int d1, int d2, logic [NPH-1:0] pv);
    rst_n   = 1'b0;
    en      = 1'b0;
    period  = CW'(p);
    dead    = CW'(dt);
    duty[0] = CW'(d0);
    duty[1] = CW'(d1);
    duty[2] = CW'(d2);
    pol     = pv;
    repeat (3) @(negedge clk);
    chk(gate_hi == pv, "R6", "gate_hi in reset", int'(gate_hi), int'(pv));
    chk(gate_lo == pv, "R6", "gate_lo in reset", int'(gate_lo), int'(pv));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(gate_hi == pv && gate_lo == pv, "R6", "gates idle before enable",
        int'({gate_hi, gate_lo}), int'({pv, pv}));
    en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    en     = 1'b0;
    period = '0;
    dead   = '0;
    duty   = '0;
    pol    = '0;

    // normal spread of duties
    apply_cfg(20, 3, 5, 10, 15, 3'b000);
    push_exp(20, 3, "R2");
    monitor_window(20, 120);
    check_gap(20, 3, 0);
    check_gap(20, 3, 1);

    // R5: one-cycle duty dip right after low-side release on leg 0
    begin
      logic prev;
      bit   done;
      done = 1'b0;
      @(negedge clk);
      prev = act_lo[0];
      for (int k = 0; k < 200 && !done; k++) begin
        @(negedge clk);
        if (prev && !act_lo[0]) begin
          duty[0] = CW'(4);
          @(negedge clk);
          duty[0] = CW'(5);
          done = 1'b1;
        end
        prev = act_lo[0];
      end
      push_exp(20, 3, "R5");
      monitor_window(20, 0);
    end

    // suppression: leg0 high side (R3), leg1 low side (R4)
    apply_cfg(20, 4, 19, 1, 10, 3'b000);
    push_exp(20, 4, "R2");
    monitor_window(20, 120);

    // polarity inversion on legs 0 and 2
    apply_cfg(16, 2, 4, 8, 12, 3'b101);
    push_exp(16, 2, "R7");
    monitor_window(16, 100);
    check_gap(16, 2, 2);

    // exact ties: 2(P-c)==D on leg0, 2c==D on leg1
    apply_cfg(20, 4, 18, 2, 12, 3'b000);
    push_exp(20, 4, "R2");
    monitor_window(20, 120);

    // R9: steady duty change while running
    duty[0] = CW'(6);
    duty[1] = CW'(14);
    duty[2] = CW'(10);
    push_exp(20, 4, "R9");
    monitor_window(20, 120);

    // R8: pause and resume
    begin
      logic [NPH-1:0] h0, l0;
      bit             moved;
      moved = 1'b0;
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      h0 = gate_hi;
      l0 = gate_lo;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (gate_hi != h0 || gate_lo != l0) moved = 1'b1;
      end
      chk(!moved, "R8", "gates moved while paused", int'(moved), 0);
      en = 1'b1;
      push_exp(20, 4, "R8");
      monitor_window(20, 80);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule